// File: doc/BRIEF.md
# Debug Access Authentication Gate

This block sits in front of a debug register space and decides which register writes may go through. It holds a 32-bit challenge and an authenticated flag. The debugger reads the challenge, adds a secret shared with the chip, and writes the sum back to the authentication data register. A matching answer sets the flag. Any other answer clears the flag and replaces the challenge, so an attacker cannot retry against a fixed value.

While the flag is clear, the debugger may still read every register. It may write only the authentication data register and the active bit of the control register. Every other write is refused with an error response and never reaches the downstream register space. The block owns the control register: the active bit, halt request, resume request, hart reset and a 10-bit hart select. Raising the active bit from 0 to 1 restarts the module, which draws a fresh challenge and drops authentication.

Requests take one cycle. The response (valid, error, read data) is registered and appears one cycle after the request. Allowed writes to other addresses are forwarded to the downstream space in the request cycle.

Top module: `auth_gate`

## Requirements
- R1: When reset is released, the authenticated flag equals the inverse of REQUIRE_AUTH. With the default REQUIRE_AUTH=1 it is 0. The control register reads 0, and the status register (address 0x11) reads 0.
- R2: While not authenticated, a write to any address other than 0x10 (control) and 0x30 (authentication data) gives rsp_err=1 in the response cycle and never raises dn_wr_en. The status register is included in this rule.
- R3: Reads never produce an error. A read of address 0x30 returns the current challenge. Repeated reads return the same value while no failed answer and no reactivation occurs.
- R4: When REQUIRE_AUTH=1, writing challenge + SECRET (modulo 2^32) to address 0x30 sets the authenticated flag (status bit 0) and leaves the challenge unchanged.
- R5: Writing any other value to address 0x30 clears the authenticated flag and loads a new challenge that differs from the previous one.
- R6: A control write with bit 0 (active) equal to 1 while active is 0 reactivates the module. It loads a new challenge and sets the flag to the inverse of REQUIRE_AUTH. When the flag is then clear, the other control fields are set to 0 and active becomes 1.
- R7: While not authenticated, a control write updates only the active bit. Halt (bit 1), resume (bit 2), hart reset (bit 3) and hart select (bits 13:4) keep their values, and no error is returned.
- R8: While authenticated, a write to an unmapped address raises dn_wr_en in the request cycle, with dn_addr/dn_wdata equal to the request and rsp_err=0. A control write with bit 0 set loads all control fields from bits 13:0.
- R9: Status bit 1 (authentication busy) always reads 0, because the comparison completes within the write cycle.
- R10: While authenticated, a control write with bit 0 clear clears active and keeps the other control fields.
- R11: The challenge source is a 32-bit Galois LFSR with a right shift and feedback mask 0x80200003. It is seeded with SEED (default 0xACE12468) at reset and advances every cycle. The challenge right after reset equals SEED.
- R12: While authenticated, a write to the status register is ignored: rsp_err=0 and the status value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Write refused |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| dn_wr_en | output | 1 | Forwarded write strobe to the downstream register space |
| dn_addr | output | 7 | Downstream address (the request address) |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data for unmapped addresses |
| ctl_active | output | 1 | Control: module active |
| ctl_halt_req | output | 1 | Control: halt request |
| ctl_resume_req | output | 1 | Control: resume request |
| ctl_hart_reset | output | 1 | Control: hart reset |
| ctl_hart_sel | output | 10 | Control: selected hart |

## Verification
The assertions assume at most one request per cycle, and that req_write, req_addr and req_wdata are known whenever req_valid is high. The bench keeps to this: it drives a single request per call, half a cycle away from the clock edge, and drops req_valid in between. The random phase keeps the active bit set. It draws downstream addresses from a range that excludes the three mapped addresses. Wrong answers are formed from a freshly read challenge with at least one bit flipped, so a "wrong" answer can never match by chance.

// File: rtl/auth_gate_pkg.sv
package auth_gate_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int HART_W = 10;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 7'h10;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 7'h11;
    localparam logic [ADDR_W-1:0] ADDR_AUTH   = 7'h30;

    localparam int STATUS_AUTH_BIT = 0;
    localparam int STATUS_BUSY_BIT = 1;

    // R11: right-shift Galois feedback mask (taps 32,22,2,1)
    localparam logic [DATA_W-1:0] LFSR_MASK = 32'h8020_0003;

    // Control register layout, LSB first: active, halt, resume, hart reset, hart select
    typedef struct packed {
        logic [HART_W-1:0] hart_sel;
        logic              hart_reset;
        logic              resume_req;
        logic              halt_req;
        logic              active;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_STATUS,
        SEL_AUTH,
        SEL_OTHER
    } sel_e;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_CTRL)        return SEL_CTRL;
        else if (a == ADDR_STATUS) return SEL_STATUS;
        else if (a == ADDR_AUTH)   return SEL_AUTH;
        else                       return SEL_OTHER;
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

    function automatic ctrl_t to_ctrl(input logic [DATA_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/auth_lfsr.sv
module auth_lfsr
    import auth_gate_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] next_val
);
    logic [DATA_W-1:0] state_q;

    // R11: free-running, seeded at reset
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q);
    end

    // Drawing the next state keeps a fresh challenge distinct from the last one
    assign next_val = lfsr_step(state_q);
endmodule

// File: rtl/auth_core.sv
module auth_core
    import auth_gate_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [DATA_W-1:0] SECRET       = 32'h5A3C_96E1,
    parameter logic [DATA_W-1:0] SEED         = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fresh_val,
    input  logic              answer_we,
    input  logic [DATA_W-1:0] answer,
    input  logic              restart,
    output logic [DATA_W-1:0] challenge,
    output logic              authed
);
    logic [DATA_W-1:0] expect_w;
    logic              match_w;

    assign expect_w = challenge + SECRET;
    assign match_w  = (answer == expect_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            challenge <= SEED;               // R11
            authed    <= !REQUIRE_AUTH;      // R1
        end else if (restart) begin
            challenge <= fresh_val;          // R6
            authed    <= !REQUIRE_AUTH;
        end else if (answer_we && REQUIRE_AUTH) begin
            if (match_w) begin
                authed <= 1'b1;              // R4
            end else begin
                authed    <= 1'b0;           // R5
                challenge <= fresh_val;
            end
        end
    end
endmodule

// File: rtl/auth_ctrl_reg.sv
module auth_ctrl_reg
    import auth_gate_pkg::*;
#(
    parameter bit REQUIRE_AUTH = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    input  logic  authed,
    output ctrl_t ctrl_q,
    output logic  restart
);
    localparam bit AUTH_AFTER_RESTART = !REQUIRE_AUTH;

    assign restart = wr_en && wr_val.active && !ctrl_q.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (restart) begin
                // R6: module restart clears fields unless access stays open
                ctrl_q        <= AUTH_AFTER_RESTART ? wr_val : '0;
                ctrl_q.active <= 1'b1;
            end else if (authed && wr_val.active) begin
                ctrl_q <= wr_val;            // R8
            end else begin
                ctrl_q.active <= wr_val.active;  // R7, R10
            end
        end
    end
endmodule

// File: rtl/auth_gate.sv
module auth_gate
    import auth_gate_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [DATA_W-1:0] SECRET       = 32'h5A3C_96E1,
    parameter logic [DATA_W-1:0] SEED         = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_wr_en,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              ctl_active,
    output logic              ctl_halt_req,
    output logic              ctl_resume_req,
    output logic              ctl_hart_reset,
    output logic [HART_W-1:0] ctl_hart_sel
);
    sel_e              sel_w;
    logic              wr_w;
    logic              permitted_w;
    logic              refuse_w;
    logic [DATA_W-1:0] rd_mux_w;
    logic [DATA_W-1:0] fresh_w;
    logic [DATA_W-1:0] chal_q;
    logic              auth_flag;
    logic              restart_w;
    ctrl_t             ctrl_q;

    assign sel_w       = decode_addr(req_addr);
    assign wr_w        = req_valid && req_write;
    assign permitted_w = auth_flag || (sel_w == SEL_CTRL) || (sel_w == SEL_AUTH);
    assign refuse_w    = wr_w && !permitted_w;   // R2

    auth_lfsr #(.SEED(SEED)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .next_val (fresh_w)
    );

    auth_core #(
        .REQUIRE_AUTH (REQUIRE_AUTH),
        .SECRET       (SECRET),
        .SEED         (SEED)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .fresh_val (fresh_w),
        .answer_we (wr_w && (sel_w == SEL_AUTH)),
        .answer    (req_wdata),
        .restart   (restart_w),
        .challenge (chal_q),
        .authed    (auth_flag)
    );

    auth_ctrl_reg #(.REQUIRE_AUTH(REQUIRE_AUTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_w && (sel_w == SEL_CTRL)),
        .wr_val  (to_ctrl(req_wdata)),
        .authed  (auth_flag),
        .ctrl_q  (ctrl_q),
        .restart (restart_w)
    );

    // R8: forwarding to the downstream space only once access is granted
    assign dn_wr_en = wr_w && (sel_w == SEL_OTHER) && auth_flag;
    assign dn_addr  = req_addr;
    assign dn_wdata = req_wdata;

    always_comb begin
        rd_mux_w = '0;
        unique case (sel_w)
            SEL_CTRL:   rd_mux_w[CTRL_W-1:0] = ctrl_q;
            SEL_STATUS: begin
                rd_mux_w[STATUS_AUTH_BIT] = auth_flag;
                rd_mux_w[STATUS_BUSY_BIT] = 1'b0;   // R9
            end
            SEL_AUTH:   rd_mux_w = chal_q;          // R3
            default:    rd_mux_w = dn_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= refuse_w;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux_w : '0;
        end
    end

    assign ctl_active     = ctrl_q.active;
    assign ctl_halt_req   = ctrl_q.halt_req;
    assign ctl_resume_req = ctrl_q.resume_req;
    assign ctl_hart_reset = ctrl_q.hart_reset;
    assign ctl_hart_sel   = ctrl_q.hart_sel;
endmodule

// File: rtl/auth_gate_chk.sv
module auth_gate_chk
    import auth_gate_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [DATA_W-1:0] SECRET       = 32'h5A3C_96E1,
    parameter logic [DATA_W-1:0] SEED         = 32'hACE1_2468
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              dn_wr_en,
    input logic              authed,
    input logic [DATA_W-1:0] chal,
    input logic [CTRL_W-1:0] ctrl_bits
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (authed == !REQUIRE_AUTH) && (ctrl_bits == '0) && (chal == SEED));

    p_no_forward_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !authed && req_addr != ADDR_CTRL && req_addr != ADDR_AUTH)
        |-> !dn_wr_en);

    p_refuse_err_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !authed && req_addr != ADDR_CTRL && req_addr != ADDR_AUTH)
        |=> rsp_valid && rsp_err);

    p_read_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid && !rsp_err);

    p_chal_read_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == ADDR_AUTH) |=> rsp_rdata == $past(chal));

    p_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (REQUIRE_AUTH && req_valid && req_write && req_addr == ADDR_AUTH
         && req_wdata == chal + SECRET) |=> authed && $stable(chal));

    p_fail_r5: assert property (@(posedge clk) disable iff (rst)
        (REQUIRE_AUTH && req_valid && req_write && req_addr == ADDR_AUTH
         && req_wdata != chal + SECRET) |=> !authed && (chal != $past(chal)));

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == ADDR_CTRL && req_wdata[0] && !ctrl_bits[0])
        |=> (authed == !REQUIRE_AUTH) && (chal != $past(chal)) && ctrl_bits[0]);

    p_locked_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == ADDR_CTRL && !authed && ctrl_bits[0])
        |=> (ctrl_bits[CTRL_W-1:1] == $past(ctrl_bits[CTRL_W-1:1]))
            && (ctrl_bits[0] == $past(req_wdata[0])) && !rsp_err);

    p_busy_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == ADDR_STATUS)
        |=> !rsp_rdata[STATUS_BUSY_BIT]);
endmodule

bind auth_gate auth_gate_chk #(
    .REQUIRE_AUTH (REQUIRE_AUTH),
    .SECRET       (SECRET),
    .SEED         (SEED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .dn_wr_en  (dn_wr_en),
    .authed    (auth_flag),
    .chal      (chal_q),
    .ctrl_bits (ctrl_q)
);

// File: tb/auth_gate_tb.sv
module auth_gate_tb;
    localparam logic [31:0] T_SECRET = 32'h1357_9BDF;
    localparam logic [31:0] T_SEED   = 32'hACE1_2468;
    localparam logic [6:0]  A_CTRL   = 7'h10;
    localparam logic [6:0]  A_STAT   = 7'h11;
    localparam logic [6:0]  A_AUTH   = 7'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_wr_en;
    logic [6:0]  dn_addr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = 32'hD0D0_0000;
    logic        ctl_active, ctl_halt_req, ctl_resume_req, ctl_hart_reset;
    logic [9:0]  ctl_hart_sel;

    int checks = 0;
    int errors = 0;

    logic        got_v, got_err, seen_dn;
    logic [31:0] got_data, seen_dn_data;
    logic [6:0]  seen_dn_addr;

    logic        m_auth;
    logic [13:0] m_ctrl;
    logic [31:0] known_chal;

    always #10 clk = ~clk;   // 50 MHz

    auth_gate #(.REQUIRE_AUTH(1'b1), .SECRET(T_SECRET), .SEED(T_SEED)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_wr_en(dn_wr_en), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .ctl_active(ctl_active), .ctl_halt_req(ctl_halt_req), .ctl_resume_req(ctl_resume_req),
        .ctl_hart_reset(ctl_hart_reset), .ctl_hart_sel(ctl_hart_sel)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        seen_dn = dn_wr_en; seen_dn_addr = dn_addr; seen_dn_data = dn_wdata;
        @(posedge clk);
        #1;
        got_v = rsp_valid; got_err = rsp_err; got_data = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] ctl_ports();
        return {18'b0, ctl_hart_sel, ctl_hart_reset, ctl_resume_req, ctl_halt_req, ctl_active};
    endfunction

    // Expected control register after a control write (R6, R7, R8, R10)
    function automatic void model_ctrl_write(input logic [31:0] d);
        if (d[0] && !m_ctrl[0]) begin
            m_auth = 1'b0;
            m_ctrl = 14'h0001;
        end else if (m_auth && d[0]) begin
            m_ctrl = d[13:0];
        end else begin
            m_ctrl[0] = d[0];
        end
    endfunction

    task automatic read_chal(input string tag);
        xfer(1'b0, A_AUTH, '0);
        chk(got_v && !got_err, tag, {31'b0, got_err}, 32'h0);
        known_chal = got_data;
    endtask

    task automatic check_status(input string tag);
        xfer(1'b0, A_STAT, '0);
        chk(got_data == {30'b0, 1'b0, m_auth}, tag, got_data, {30'b0, 1'b0, m_auth});
    endtask

    task automatic check_ctrl(input string tag);
        chk(ctl_ports() == {18'b0, m_ctrl}, tag, ctl_ports(), {18'b0, m_ctrl});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        void'($urandom(32'd20240611));
        m_auth = 1'b0; m_ctrl = '0; known_chal = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check_status("R1 status after reset");
        xfer(1'b0, A_CTRL, '0);
        chk(got_data == 32'h0, "R1 control read after reset", got_data, 32'h0);
        check_ctrl("R1 control outputs after reset");

        // R11 / R3: challenge after reset is the seed and reads are stable
        read_chal("R3 challenge read no error");
        chk(known_chal == T_SEED, "R11 challenge equals seed", known_chal, T_SEED);
        xfer(1'b0, A_AUTH, '0);
        chk(got_data == T_SEED, "R3 repeat challenge read", got_data, T_SEED);

        // R2: refused writes while locked
        xfer(1'b1, 7'h05, 32'hCAFE_0001);
        chk(seen_dn == 1'b0, "R2 no forward while locked", {31'b0, seen_dn}, 32'h0);
        chk(got_err == 1'b1, "R2 error on locked write", {31'b0, got_err}, 32'h1);
        xfer(1'b1, A_STAT, 32'h1);
        chk(got_err == 1'b1, "R2 status write refused", {31'b0, got_err}, 32'h1);
        check_status("R2 status unchanged");

        // R6: reactivation while locked
        prev = known_chal;
        xfer(1'b1, A_CTRL, 32'h0000_3FFF);
        model_ctrl_write(32'h0000_3FFF);
        chk(got_err == 1'b0, "R6 reactivation no error", {31'b0, got_err}, 32'h0);
        check_ctrl("R6 fields cleared on restart");
        read_chal("R6 read");
        chk(known_chal != prev, "R6 new challenge on restart", known_chal, prev);

        // R7: locked control writes touch only active
        xfer(1'b1, A_CTRL, 32'h0000_3FFF);
        model_ctrl_write(32'h0000_3FFF);
        chk(got_err == 1'b0, "R7 locked control write no error", {31'b0, got_err}, 32'h0);
        check_ctrl("R7 fields held while locked");
        xfer(1'b1, A_CTRL, 32'h0000_3FFE);
        model_ctrl_write(32'h0000_3FFE);
        check_ctrl("R7 active cleared while locked");
        prev = known_chal;
        read_chal("R7 read");
        chk(known_chal == prev, "R7 challenge kept without restart", known_chal, prev);
        xfer(1'b1, A_CTRL, 32'h0000_0001);
        model_ctrl_write(32'h0000_0001);
        read_chal("R6 read 2");
        chk(known_chal != prev, "R6 second restart new challenge", known_chal, prev);

        // R5: wrong answer
        prev = known_chal;
        xfer(1'b1, A_AUTH, (prev + T_SECRET) ^ 32'h0000_0100);
        m_auth = 1'b0;
        check_status("R5 still locked after wrong answer");
        read_chal("R5 read");
        chk(known_chal != prev, "R5 new challenge after wrong answer", known_chal, prev);

        // R4 / R9: right answer
        prev = known_chal;
        xfer(1'b1, A_AUTH, prev + T_SECRET);
        chk(got_err == 1'b0, "R4 answer write no error", {31'b0, got_err}, 32'h0);
        m_auth = 1'b1;
        check_status("R4 R9 authenticated, busy bit 0");
        read_chal("R4 read");
        chk(known_chal == prev, "R4 challenge kept on success", known_chal, prev);

        // R8: forwarding and full control write
        xfer(1'b1, 7'h22, 32'h1234_5678);
        chk(seen_dn && seen_dn_addr == 7'h22 && seen_dn_data == 32'h1234_5678,
            "R8 write forwarded", {seen_dn, 24'b0, seen_dn_addr}, {1'b1, 24'b0, 7'h22});
        chk(got_err == 1'b0, "R8 no error when open", {31'b0, got_err}, 32'h0);
        xfer(1'b1, A_CTRL, 32'h0000_2A57);
        model_ctrl_write(32'h0000_2A57);
        check_ctrl("R8 control fields loaded");
        xfer(1'b0, A_CTRL, '0);
        chk(got_data == {18'b0, m_ctrl}, "R8 control readback", got_data, {18'b0, m_ctrl});

        // R10: active cleared, fields kept
        xfer(1'b1, A_CTRL, 32'h0000_0000);
        model_ctrl_write(32'h0000_0000);
        check_ctrl("R10 active cleared fields kept");

        // R12: status write ignored when open
        xfer(1'b1, A_STAT, 32'h0000_0000);
        chk(got_err == 1'b0, "R12 status write no error", {31'b0, got_err}, 32'h0);
        check_status("R12 status unchanged");

        // R6: restart while authenticated drops access
        xfer(1'b1, A_CTRL, 32'h0000_3FFF);
        model_ctrl_write(32'h0000_3FFF);
        check_status("R6 restart clears authentication");
        check_ctrl("R6 restart clears fields");

        // Random phase, active stays set
        read_chal("R3 random setup");
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 5);
            d  = $urandom;
            case (op)
                0: begin
                    prev = known_chal;
                    xfer(1'b0, A_AUTH, '0);
                    chk(got_data == prev, "R3 random challenge read", got_data, prev);
                end
                1: begin
                    read_chal("R4 random read");
                    xfer(1'b1, A_AUTH, known_chal + T_SECRET);
                    m_auth = 1'b1;
                    check_status("R4 random success");
                end
                2: begin
                    read_chal("R5 random read");
                    prev = known_chal;
                    xfer(1'b1, A_AUTH, (prev + T_SECRET) ^ (d | 32'h1));
                    m_auth = 1'b0;
                    check_status("R5 random failure");
                    read_chal("R5 random reread");
                    chk(known_chal != prev, "R5 random new challenge", known_chal, prev);
                end
                3: begin
                    logic [6:0] a;
                    a = 7'($urandom_range(0, 15));
                    xfer(1'b1, a, d);
                    chk(seen_dn == m_auth && (!m_auth || seen_dn_data == d),
                        m_auth ? "R8 random forward" : "R2 random block",
                        {31'b0, seen_dn}, {31'b0, m_auth});
                    chk(got_err == !m_auth, m_auth ? "R8 random no error" : "R2 random error",
                        {31'b0, got_err}, {31'b0, !m_auth});
                end
                4: begin
                    xfer(1'b1, A_CTRL, d | 32'h1);
                    model_ctrl_write(d | 32'h1);
                    check_ctrl(m_auth ? "R8 random control load" : "R7 random control hold");
                end
                default: check_status("R9 random status read");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule